// File: doc/BRIEF.md
# Low-Power Mode Recovery Controller

This controller puts a small processor system into one of two low-power states and brings it back out. In the light state (wait), only the CPU clock is gated and the peripherals keep running. In the deep state (stop), the CPU clock and the peripheral clocks are both gated. The controller then holds the CPU until the oscillator has had time to settle. The CPU asks for either state with a request line. Three wake sources end a low-power state:

- an interrupt request;
- a debug break request;
- an external reset pin.

An interrupt or break wake ends in a one-cycle strobe that lets the CPU start stacking its context. A reset-pin wake runs a two-phase hold and then strobes the two halves of the reset vector fetch.

A single counter measures every delay. It runs on the always-running internal clock. The stop recovery length is 4096 or 32 cycles, chosen by a configuration input. The two reset phases are 32 cycles each. All outputs are decoded from the registered state, so each one changes only just after a clock edge.

The states and their transitions are as follows:

- **S_RUN**
  - goes to S_STOP on a stop request;
  - otherwise goes to S_WAIT on a wait request.
- **S_WAIT**
  - goes to S_RESUME on an interrupt or break.
- **S_STOP**
  - goes to S_STOP_REC on an interrupt or break.
- **S_STOP_REC**
  - goes to S_RESUME when the selected count expires.
- **S_RESUME**
  - issues the stacking strobe;
  - returns to S_RUN.
- **S_RST_A**
  - goes to S_RST_B after 32 cycles.
- **S_RST_B**
  - goes to S_VEC_HI after 32 cycles.
- **S_VEC_HI**
  - goes to S_VEC_LO.
- **S_VEC_LO**
  - goes to S_RUN.
- **From any state**, the reset pin forces S_RST_A and clears the counter.

Top module: `lpm_recovery_ctrl`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, mode is RUN (code 0), both clock enables are 1, and cpu_hold, stack_go, vec_hi_go and vec_lo_go are 0.
- R2: wait_req sampled high in RUN gives, from the next cycle, mode WAIT (code 1) with cpu_clk_en 0, periph_clk_en 1 and cpu_hold 1.
- R3: stop_req sampled high in RUN gives, from the next cycle, mode STOP (code 2) with both clock enables 0 and cpu_hold 1; stop_req wins when wait_req is also high.
- R4: irq_req or brk_req sampled high in WAIT gives, on the next cycle, stack_go 1 with cpu_clk_en 1 and mode RUN for exactly one cycle, then plain RUN.
- R5: irq_req or brk_req sampled high in STOP starts a recovery. During it, mode is RECOVER (code 3), both clocks are off and cpu_hold is 1. It lasts exactly 4096 cycles when short_rec was 0 at the wake edge.
- R6: The same recovery lasts exactly 32 cycles when short_rec was 1 at the wake edge.
- R7: After a stop wake, stack_go stays 0 until the recovery count has fully expired, and rises on the cycle right after the last recovery cycle.
- R8: short_rec is sampled only at the edge that ends STOP; changing it during the recovery has no effect on the recovery length.
- R9: rst_pin sampled high in any state gives, next cycle, mode RECOVER with both clocks on and cpu_hold 1. After the pin is released, 64 such cycles follow, then one cycle of vec_hi_go, then one cycle of vec_lo_go (both with cpu_hold 0), then RUN.
- R10: rst_pin during a stop recovery aborts the count: no stack_go is issued, and the reset sequence of R9 runs instead.
- R11: wait_req and stop_req are ignored outside RUN, and irq_req and brk_req are ignored in RUN and in the reset sequence; no stack_go is issued in those cases.
- R12: Holding rst_pin high keeps restarting the first reset phase, so the 64-cycle hold of R9 is counted from the last cycle the pin was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running internal clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wait_req | input | 1 | CPU request to enter the wait state |
| stop_req | input | 1 | CPU request to enter the stop state |
| rst_pin | input | 1 | External reset pin, active high, also a wake source |
| irq_req | input | 1 | CPU interrupt request (wake source) |
| brk_req | input | 1 | Debug break request (wake source) |
| short_rec | input | 1 | Configuration: 1 selects the short stop recovery |
| cpu_clk_en | output | 1 | Gate for the CPU clock |
| periph_clk_en | output | 1 | Gate for the peripheral clocks |
| cpu_hold | output | 1 | Holds the CPU stalled |
| stack_go | output | 1 | One-cycle strobe: interrupt stacking may start |
| vec_hi_go | output | 1 | One-cycle strobe: fetch reset vector high byte |
| vec_lo_go | output | 1 | One-cycle strobe: fetch reset vector low byte |
| mode | output | 2 | Current mode: 0 RUN, 1 WAIT, 2 STOP, 3 RECOVER |

## Verification
The hardest case to reach from the ports is a reset pin that arrives partway through a stop recovery. It must kill the pending stacking strobe and hand the shared counter to the reset phases, cleared to zero. The stimulus gets there by waking from stop with the short delay, letting ten recovery cycles run, and then pulsing the reset pin for one cycle. It then confirms that no stacking strobe appears and that exactly 64 hold cycles pass before the high-byte strobe. A separate pass holds the pin high for several cycles out of wait, to show that the hold is counted from the pin's release.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [3:0] {
        S_RUN,
        S_RESUME,
        S_WAIT,
        S_STOP,
        S_STOP_REC,
        S_RST_A,
        S_RST_B,
        S_VEC_HI,
        S_VEC_LO
    } lpm_state_e;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_WAIT    = 2'd1,
        MODE_STOP    = 2'd2,
        MODE_RECOVER = 2'd3
    } lpm_mode_e;

    typedef struct packed {
        logic      cpu_clk_en;
        logic      periph_clk_en;
        logic      cpu_hold;
        logic      stack_go;
        logic      vec_hi_go;
        logic      vec_lo_go;
        lpm_mode_e mode;
    } lpm_out_t;

endpackage

// File: rtl/lpm_rec_counter.sv
module lpm_rec_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] term,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign done = en && (cnt == term);

    // A cleared count starts from zero (stop entry and phase changes)
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // The count never runs past the selected terminal value
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= term));

endmodule

// File: rtl/lpm_delay_sel.sv
module lpm_delay_sel #(
    parameter int CNT_W     = 12,
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32,
    parameter int RST_PHASE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             short_rec,
    input  logic             use_stop,
    output logic [CNT_W-1:0] term
);

    localparam logic [CNT_W-1:0] LONG_TERM  = CNT_W'(LONG_DLY - 1);
    localparam logic [CNT_W-1:0] SHORT_TERM = CNT_W'(SHORT_DLY - 1);
    localparam logic [CNT_W-1:0] RST_TERM   = CNT_W'(RST_PHASE - 1);

    logic short_q;

    // Tracks the configuration bit while stopped; frozen once recovery runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
        end else if (capture) begin
            short_q <= short_rec;
        end
    end

    always_comb begin
        if (use_stop) begin
            term = short_q ? SHORT_TERM : LONG_TERM;
        end else begin
            term = RST_TERM;
        end
    end

    // Recovery length choice cannot change mid-count
    p_short_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(use_stop) && use_stop) |-> $stable(short_q));

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       rst_pin,
    input  logic       irq_req,
    input  logic       brk_req,
    input  logic       cnt_done,
    output logic       cnt_clr,
    output logic       cnt_en,
    output logic       capture,
    output logic       use_stop,
    output lpm_out_t   outs
);

    lpm_state_e st, nxt;
    logic       wake_int;

    assign wake_int = irq_req || brk_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_RUN;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic; the reset pin overrides every state
    always_comb begin
        nxt = st;
        if (rst_pin) begin
            nxt = S_RST_A;
        end else begin
            unique case (st)
                S_RUN: begin
                    if (stop_req) begin
                        nxt = S_STOP;
                    end else if (wait_req) begin
                        nxt = S_WAIT;
                    end
                end
                S_RESUME:   nxt = S_RUN;
                S_WAIT:     if (wake_int) nxt = S_RESUME;
                S_STOP:     if (wake_int) nxt = S_STOP_REC;
                S_STOP_REC: if (cnt_done) nxt = S_RESUME;
                S_RST_A:    if (cnt_done) nxt = S_RST_B;
                S_RST_B:    if (cnt_done) nxt = S_VEC_HI;
                S_VEC_HI:   nxt = S_VEC_LO;
                S_VEC_LO:   nxt = S_RUN;
                default:    nxt = S_RUN;
            endcase
        end
    end

    // Counter control: clear on every state change or reset-pin restart
    assign cnt_clr  = (nxt != st) || rst_pin;
    assign cnt_en   = (st == S_STOP_REC) || (st == S_RST_A) || (st == S_RST_B);
    assign capture  = (st == S_STOP);
    assign use_stop = (st == S_STOP_REC);

    // Output decode from the registered state
    always_comb begin
        outs.cpu_clk_en    = 1'b1;
        outs.periph_clk_en = 1'b1;
        outs.cpu_hold      = 1'b0;
        outs.stack_go      = 1'b0;
        outs.vec_hi_go     = 1'b0;
        outs.vec_lo_go     = 1'b0;
        outs.mode          = MODE_RUN;
        unique case (st)
            S_RUN: begin
            end
            S_RESUME: begin
                outs.stack_go = 1'b1;
            end
            S_WAIT: begin
                outs.cpu_clk_en = 1'b0;
                outs.cpu_hold   = 1'b1;
                outs.mode       = MODE_WAIT;
            end
            S_STOP: begin
                outs.cpu_clk_en    = 1'b0;
                outs.periph_clk_en = 1'b0;
                outs.cpu_hold      = 1'b1;
                outs.mode          = MODE_STOP;
            end
            S_STOP_REC: begin
                outs.cpu_clk_en    = 1'b0;
                outs.periph_clk_en = 1'b0;
                outs.cpu_hold      = 1'b1;
                outs.mode          = MODE_RECOVER;
            end
            S_RST_A, S_RST_B: begin
                outs.cpu_hold = 1'b1;
                outs.mode     = MODE_RECOVER;
            end
            S_VEC_HI: begin
                outs.vec_hi_go = 1'b1;
                outs.mode      = MODE_RECOVER;
            end
            S_VEC_LO: begin
                outs.vec_lo_go = 1'b1;
                outs.mode      = MODE_RECOVER;
            end
            default: begin
            end
        endcase
    end

    // Wait wake by interrupt or break resumes the CPU with the strobe
    p_wait_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && !rst_pin && wake_int) |=> (outs.stack_go && outs.cpu_clk_en));

    p_stack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        outs.stack_go |=> !outs.stack_go);

    // Stop request beats wait request
    p_stop_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && stop_req && !rst_pin) |=> (outs.mode == MODE_STOP));

    // No stacking while the recovery count is still running
    p_stack_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STOP_REC && !cnt_done && !rst_pin) |=> !outs.stack_go);

    // Reset pin aborts a stop recovery
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STOP_REC && rst_pin) |=> (st == S_RST_A && !outs.stack_go));

    p_rst_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin |=> (st == S_RST_A && outs.cpu_hold));

    p_vec_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        outs.vec_lo_go |-> $past(outs.vec_hi_go));

    // Wake inputs in RUN do nothing
    p_run_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && !rst_pin && !stop_req && !wait_req) |=>
            (!outs.stack_go && outs.mode == MODE_RUN));

endmodule

// File: rtl/lpm_recovery_ctrl.sv
module lpm_recovery_ctrl
    import lpm_pkg::*;
#(
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32,
    parameter int RST_PHASE = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       rst_pin,
    input  logic       irq_req,
    input  logic       brk_req,
    input  logic       short_rec,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       cpu_hold,
    output logic       stack_go,
    output logic       vec_hi_go,
    output logic       vec_lo_go,
    output logic [1:0] mode
);

    localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ?
                             ((LONG_DLY > RST_PHASE) ? LONG_DLY : RST_PHASE) :
                             ((SHORT_DLY > RST_PHASE) ? SHORT_DLY : RST_PHASE);
    localparam int CNT_W   = (MAX_DLY > 2) ? $clog2(MAX_DLY) : 1;

    logic             cnt_clr;
    logic             cnt_en;
    logic             cnt_done;
    logic             capture;
    logic             use_stop;
    logic [CNT_W-1:0] term;
    lpm_out_t         outs;

    lpm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_req (wait_req),
        .stop_req (stop_req),
        .rst_pin  (rst_pin),
        .irq_req  (irq_req),
        .brk_req  (brk_req),
        .cnt_done (cnt_done),
        .cnt_clr  (cnt_clr),
        .cnt_en   (cnt_en),
        .capture  (capture),
        .use_stop (use_stop),
        .outs     (outs)
    );

    lpm_delay_sel #(
        .CNT_W     (CNT_W),
        .LONG_DLY  (LONG_DLY),
        .SHORT_DLY (SHORT_DLY),
        .RST_PHASE (RST_PHASE)
    ) u_dsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .short_rec (short_rec),
        .use_stop  (use_stop),
        .term      (term)
    );

    lpm_rec_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .term  (term),
        .done  (cnt_done)
    );

    assign cpu_clk_en    = outs.cpu_clk_en;
    assign periph_clk_en = outs.periph_clk_en;
    assign cpu_hold      = outs.cpu_hold;
    assign stack_go      = outs.stack_go;
    assign vec_hi_go     = outs.vec_hi_go;
    assign vec_lo_go     = outs.vec_lo_go;
    assign mode          = outs.mode;

endmodule

// File: tb/lpm_recovery_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_recovery_ctrl_bench;

    localparam int LONG_D  = 4096;
    localparam int SHORT_D = 32;
    localparam int PH_D    = 32;
    localparam int WD_LIM  = 150000;

    localparam int M_RUN = 0, M_RES = 1, M_WAIT = 2, M_STOP = 3, M_SREC = 4,
                   M_RA = 5, M_RB = 6, M_VH = 7, M_VL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req = 0, stop_req = 0, rst_pin = 0, irq_req = 0, brk_req = 0, short_rec = 0;
    logic cpu_clk_en, periph_clk_en, cpu_hold, stack_go, vec_hi_go, vec_lo_go;
    logic [1:0] mode;

    always #4 clk = ~clk;

    lpm_recovery_ctrl u_lpm_recovery_ctrl (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .rst_pin(rst_pin), .irq_req(irq_req), .brk_req(brk_req), .short_rec(short_rec),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .cpu_hold(cpu_hold),
        .stack_go(stack_go), .vec_hi_go(vec_hi_go), .vec_lo_go(vec_lo_go), .mode(mode)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: mode index plus remaining-cycle countdown
    int m_st  = M_RUN;
    int m_rem = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st  <= M_RUN;
            m_rem <= 0;
        end else if (rst_pin) begin
            m_st  <= M_RA;
            m_rem <= PH_D;
        end else begin
            case (m_st)
                M_RUN:  if (stop_req) m_st <= M_STOP; else if (wait_req) m_st <= M_WAIT;
                M_RES:  m_st <= M_RUN;
                M_WAIT: if (irq_req || brk_req) m_st <= M_RES;
                M_STOP: if (irq_req || brk_req) begin
                            m_st  <= M_SREC;
                            m_rem <= short_rec ? SHORT_D : LONG_D;
                        end
                M_SREC: if (m_rem == 1) m_st <= M_RES; else m_rem <= m_rem - 1;
                M_RA:   if (m_rem == 1) begin m_st <= M_RB; m_rem <= PH_D; end
                        else m_rem <= m_rem - 1;
                M_RB:   if (m_rem == 1) m_st <= M_VH; else m_rem <= m_rem - 1;
                M_VH:   m_st <= M_VL;
                default: m_st <= M_RUN;
            endcase
        end
    end

    function automatic logic [7:0] expect_vec(input int s);
        // {cpu_clk, periph_clk, hold, stack, vhi, vlo, mode[1:0]}
        case (s)
            M_RES:  return 8'b1101_0000;
            M_WAIT: return 8'b0110_0001;
            M_STOP: return 8'b0010_0010;
            M_SREC: return 8'b0010_0011;
            M_RA, M_RB: return 8'b1110_0011;
            M_VH:   return 8'b1100_1011;
            M_VL:   return 8'b1100_0111;
            default: return 8'b1100_0000;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            M_WAIT: return "R2";
            M_STOP: return "R3";
            M_RES:  return "R4";
            M_SREC: return "R5";
            M_RA, M_RB, M_VH, M_VL: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            logic [7:0] act;
            logic [7:0] exp;
            act = {cpu_clk_en, periph_clk_en, cpu_hold, stack_go, vec_hi_go, vec_lo_go, mode};
            exp = expect_vec(m_st);
            chk(act == exp, tag_of(m_st), "output vector vs model", int'(act), int'(exp));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD_LIM && !ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cycles, WD_LIM);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_recover(output int n);
        n = 0;
        while (mode == 2'd3 && !vec_hi_go && n < 10000) begin
            if (stack_go) chk(0, "R7", "stack_go during recovery", 1, 0);
            n++;
            cyc();
        end
    endtask

    initial begin
        int n;
        int stk;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(mode == 2'd0 && cpu_clk_en && periph_clk_en && !cpu_hold && !stack_go,
            "R1", "reset outputs", int'(mode), 0);
        rst_n = 1'b1;
        cyc();
        chk(mode == 2'd0 && !vec_hi_go && !vec_lo_go, "R1", "first cycle after reset", int'(mode), 0);

        // R11: wake inputs in RUN
        irq_req = 1; brk_req = 1;
        cyc();
        irq_req = 0; brk_req = 0;
        chk(stack_go == 0, "R11", "stack_go after wake in RUN", int'(stack_go), 0);

        // R2: wait entry
        wait_req = 1;
        cyc();
        wait_req = 0;
        chk(mode == 2'd1 && !cpu_clk_en && periph_clk_en && cpu_hold, "R2", "wait mode", int'(mode), 1);
        stop_req = 1;
        cyc();
        stop_req = 0;
        chk(mode == 2'd1, "R11", "stop_req ignored in wait", int'(mode), 1);

        // R4: wake by interrupt
        irq_req = 1;
        cyc();
        irq_req = 0;
        chk(stack_go && cpu_clk_en && mode == 2'd0, "R4", "stack_go after wait irq", int'(stack_go), 1);
        cyc();
        chk(!stack_go && mode == 2'd0, "R4", "stack_go single cycle", int'(stack_go), 0);

        // R4: wake by break
        wait_req = 1;
        cyc();
        wait_req = 0;
        brk_req = 1;
        cyc();
        brk_req = 0;
        chk(stack_go == 1, "R4", "stack_go after wait break", int'(stack_go), 1);
        cyc();

        // R3: stop wins over wait
        stop_req = 1; wait_req = 1;
        cyc();
        stop_req = 0; wait_req = 0;
        chk(mode == 2'd2 && !cpu_clk_en && !periph_clk_en && cpu_hold, "R3", "stop priority", int'(mode), 2);

        // R6 and R8: short recovery, config toggled during the count
        short_rec = 1; brk_req = 1;
        cyc();
        brk_req = 0; short_rec = 0;
        wait_req = 1; stop_req = 1;
        count_recover(n);
        wait_req = 0; stop_req = 0;
        chk(n == SHORT_D, "R6", "short recovery length", n, SHORT_D);
        chk(n == SHORT_D, "R8", "config change mid-count ignored", n, SHORT_D);
        chk(stack_go == 1, "R7", "stack_go right after expiry", int'(stack_go), 1);
        cyc();

        // R5: long recovery
        stop_req = 1;
        cyc();
        stop_req = 0;
        irq_req = 1;
        cyc();
        irq_req = 0;
        count_recover(n);
        chk(n == LONG_D, "R5", "long recovery length", n, LONG_D);
        chk(stack_go == 1, "R7", "stack_go after long expiry", int'(stack_go), 1);
        cyc();

        // R10: reset pin aborts a stop recovery
        short_rec = 1; stop_req = 1;
        cyc();
        stop_req = 0; irq_req = 1;
        cyc();
        irq_req = 0;
        repeat (10) cyc();
        rst_pin = 1;
        cyc();
        rst_pin = 0;
        chk(mode == 2'd3 && cpu_clk_en && periph_clk_en && cpu_hold, "R9", "reset hold outputs", int'(mode), 3);
        stk = 0;
        n = 0;
        while (!vec_hi_go && n < 10000) begin
            if (stack_go) stk++;
            n++;
            cyc();
        end
        chk(stk == 0, "R10", "no stack_go after abort", stk, 0);
        chk(n == 2 * PH_D, "R10", "reset hold length after abort", n, 2 * PH_D);
        chk(vec_hi_go && !cpu_hold, "R9", "vector high strobe", int'(vec_hi_go), 1);
        cyc();
        chk(vec_lo_go && !vec_hi_go, "R9", "vector low strobe", int'(vec_lo_go), 1);
        cyc();
        chk(mode == 2'd0 && !vec_lo_go, "R9", "back to run", int'(mode), 0);

        // R12: reset pin held, out of wait
        wait_req = 1;
        cyc();
        wait_req = 0;
        rst_pin = 1;
        repeat (5) cyc();
        irq_req = 1;
        cyc();
        irq_req = 0;
        rst_pin = 0;
        n = 0;
        while (!vec_hi_go && n < 10000) begin
            n++;
            cyc();
        end
        chk(n == 2 * PH_D, "R12", "hold counted from pin release", n, 2 * PH_D);
        repeat (3) cyc();
        chk(mode == 2'd0, "R9", "run after held reset", int'(mode), 0);

        ended = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule